// File: doc/BRIEF.md
# Voice Interrupt Source Queue

This block collects interrupt events from the voices of a wavetable synthesizer. Each voice can raise two kinds of event: the end of its waveform and the end of its volume ramp. Each kind is held in its own pending mask, with one bit per voice. A host driver services the events one at a time. It writes the pop code to the function-select register, and the block then hands back the number of one pending voice, formatted into a status byte the host can read.

The pop chooses the lowest-numbered pending waveform voice. Only when no waveform event is pending at all does it look at the volume-ramp mask. Along with the status byte, the block emits a one-cycle clear strobe for the popped voice, so that the voice's control register can drop its own interrupt bit. Two summary flags feed the global interrupt status register. The interrupt request also takes into account the other sources that share that register. A write to the card reset register with bit 0 low empties both masks.

Top module: `voice_irq_queue`

## Requirements
- R1: A pop happens only on a cycle where `fsel_wr_i` is high and `fsel_data_i` equals 0x8F. A function-select write of any other value leaves `status_o` unchanged and produces no clear strobe.
- R2: A pop takes the lowest-indexed pending voice within the scanned range, which is voices 0 through `SCAN_VOICES-1` (0 to 30 by default).
- R3: When the waveform mask is non-empty, a pop takes only from the waveform mask and leaves the volume-ramp mask untouched.
- R4: The cycle after a pop, `status_o` reads 0x60 OR voice for a waveform pop, 0x80 OR voice for a ramp pop, and 0xE8 when nothing is taken. The value holds until the next pop. After reset it reads 0xE8.
- R5: A pop that takes voice v drives `wave_clr_o[v]` or `ramp_clr_o[v]` high for exactly the next cycle. At most one clear bit is high in any cycle.
- R6: `gstat_wave_o` (global status bit 5) is high exactly while the waveform mask is non-empty. `gstat_ramp_o` (bit 6) is high exactly while the ramp mask is non-empty. Each falls in the cycle after the pop that takes the last bit of its mask.
- R7: `irq_o` is high while either summary flag or `other_irq_i` is high. It falls when all three are low.
- R8: A write of `crst_wr_i` with `crst_data_i[0]` = 0 empties both masks at the next edge. It overrides set pulses in the same cycle and cancels a pop in the same cycle, which leaves the status byte as it was. With bit 0 = 1 the write has no effect.
- R9: A set pulse arriving in the same cycle as the pop of that same voice leaves the voice pending.
- R10: A pending waveform voice above the scanned range (voice 31 by default) is never taken. While it is the only waveform bit, a pop returns 0xE8, clears nothing, and does not examine the ramp mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wave_set_i | input | NUM_VOICES | Per-voice waveform-end set pulses |
| ramp_set_i | input | NUM_VOICES | Per-voice volume-ramp-end set pulses |
| fsel_wr_i | input | 1 | Function-select register write strobe |
| fsel_data_i | input | 8 | Function-select write data (0x8F pops) |
| crst_wr_i | input | 1 | Card reset register write strobe |
| crst_data_i | input | 8 | Card reset write data (bit 0 low resets) |
| other_irq_i | input | 1 | Any other global status source pending |
| status_o | output | 8 | Popped-voice status byte |
| wave_clr_o | output | NUM_VOICES | Clear strobe for a voice's waveform IRQ bit |
| ramp_clr_o | output | NUM_VOICES | Clear strobe for a voice's ramp IRQ bit |
| gstat_wave_o | output | 1 | Global status bit 5: waveform pending |
| gstat_ramp_o | output | 1 | Global status bit 6: ramp pending |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a waveform mask holding only the unscanned top voice while ramp events are also pending. In that state a pop must return the idle code and starve the ramp mask. The directed stimulus builds this state on purpose: it pulses voice 31's waveform set together with a ramp voice, then pops. A set pulse on the very voice being popped in the same cycle is also driven on purpose. Long random runs then mix sparse set pulses, pops, stray function-select writes and card resets against a behavioural queue model.

// File: rtl/voiceq_pkg.sv
package voiceq_pkg;

   localparam logic [7:0] POP_CODE  = 8'h8F;
   localparam logic [7:0] WAVE_TAG  = 8'h60;
   localparam logic [7:0] RAMP_TAG  = 8'h80;
   localparam logic [7:0] IDLE_CODE = 8'hE8;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_WAVE = 2'd1,
      SRC_RAMP = 2'd2
   } src_e;

   function automatic logic [7:0] format_status(src_e s, logic [4:0] v);
      case (s)
         SRC_WAVE: return WAVE_TAG | {3'b000, v};
         SRC_RAMP: return RAMP_TAG | {3'b000, v};
         default:  return IDLE_CODE;
      endcase
   endfunction

endpackage

// File: rtl/voiceq_prio_enc.sv
// Lowest-index-first grant over the scanned part of a request vector.
module voiceq_prio_enc #(
   parameter int WIDTH = 32,
   parameter int SCAN  = 31,
   parameter int IDX_W = 5
) (
   input  logic [WIDTH-1:0] req_i,
   output logic             any_o,
   output logic             hit_o,
   output logic [WIDTH-1:0] grant_o,
   output logic [IDX_W-1:0] idx_o
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= SCAN) begin : g_dead
         assign grant_o[i] = 1'b0;
      end else if (i == 0) begin : g_first
         assign grant_o[i] = req_i[0];
      end else begin : g_live
         assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
      end
   end

   assign any_o = |req_i;
   assign hit_o = |grant_o;

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < WIDTH; i++) begin
         if (grant_o[i]) idx_o = IDX_W'(i);
      end
   end

endmodule

// File: rtl/voiceq_mask_bank.sv
// One pending mask: set pulses win over a same-cycle take, wipe wins over all.
module voiceq_mask_bank #(
   parameter int WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] take_i,
   input  logic             wipe_i,
   output logic [WIDTH-1:0] mask_o
);

   logic [WIDTH-1:0] mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mask_q <= '0;
      else if (wipe_i) mask_q <= '0;
      else             mask_q <= (mask_q & ~take_i) | set_i;
   end

   assign mask_o = mask_q;

endmodule

// File: rtl/voiceq_pop_ctrl.sv
// Chooses the source of a pop, forms the status byte and the clear strobes.
module voiceq_pop_ctrl
   import voiceq_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int IDX_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             pop_i,
   input  logic             wave_any_i,
   input  logic             wave_hit_i,
   input  logic [WIDTH-1:0] wave_grant_i,
   input  logic [IDX_W-1:0] wave_idx_i,
   input  logic             ramp_hit_i,
   input  logic [WIDTH-1:0] ramp_grant_i,
   input  logic [IDX_W-1:0] ramp_idx_i,
   output logic [WIDTH-1:0] wave_take_o,
   output logic [WIDTH-1:0] ramp_take_o,
   output logic [7:0]       status_o,
   output logic [WIDTH-1:0] wave_clr_o,
   output logic [WIDTH-1:0] ramp_clr_o
);

   src_e       src;
   logic [4:0] voice;
   logic [7:0] status_q;
   logic [WIDTH-1:0] wclr_q, rclr_q;

   // Any waveform bit, even an unscanned one, blocks the ramp mask.
   always_comb begin
      src = SRC_NONE;
      if (pop_i) begin
         if (wave_any_i) begin
            if (wave_hit_i) src = SRC_WAVE;
         end else if (ramp_hit_i) begin
            src = SRC_RAMP;
         end
      end
   end

   assign voice       = (src == SRC_WAVE) ? 5'(wave_idx_i) : 5'(ramp_idx_i);
   assign wave_take_o = (src == SRC_WAVE) ? wave_grant_i : '0;
   assign ramp_take_o = (src == SRC_RAMP) ? ramp_grant_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         status_q <= IDLE_CODE;
         wclr_q   <= '0;
         rclr_q   <= '0;
      end else begin
         if (pop_i) status_q <= format_status(src, voice);
         wclr_q <= wave_take_o;
         rclr_q <= ramp_take_o;
      end
   end

   assign status_o   = status_q;
   assign wave_clr_o = wclr_q;
   assign ramp_clr_o = rclr_q;

endmodule

// File: rtl/voice_irq_queue.sv
module voice_irq_queue
   import voiceq_pkg::*;
#(
   parameter int NUM_VOICES  = 32,
   parameter int SCAN_VOICES = 31
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_VOICES-1:0] wave_set_i,
   input  logic [NUM_VOICES-1:0] ramp_set_i,
   input  logic                  fsel_wr_i,
   input  logic [7:0]            fsel_data_i,
   input  logic                  crst_wr_i,
   input  logic [7:0]            crst_data_i,
   input  logic                  other_irq_i,
   output logic [7:0]            status_o,
   output logic [NUM_VOICES-1:0] wave_clr_o,
   output logic [NUM_VOICES-1:0] ramp_clr_o,
   output logic                  gstat_wave_o,
   output logic                  gstat_ramp_o,
   output logic                  irq_o
);

   localparam int IDX_W = (NUM_VOICES > 1) ? $clog2(NUM_VOICES) : 1;

   if (NUM_VOICES < 2 || NUM_VOICES > 32) begin : g_bad_voices
      $error("NUM_VOICES must lie in 2..32 to fit the status byte");
   end
   if (SCAN_VOICES < 1 || SCAN_VOICES > NUM_VOICES) begin : g_bad_scan
      $error("SCAN_VOICES must lie in 1..NUM_VOICES");
   end

   logic                  wipe, pop;
   logic [NUM_VOICES-1:0] wave_mask, ramp_mask;
   logic [NUM_VOICES-1:0] wave_grant, ramp_grant, wave_take, ramp_take;
   logic [IDX_W-1:0]      wave_idx, ramp_idx;
   logic                  wave_any, wave_hit, ramp_any, ramp_hit;

   assign wipe = crst_wr_i & ~crst_data_i[0];
   assign pop  = fsel_wr_i & (fsel_data_i == POP_CODE) & ~wipe;

   voiceq_mask_bank #(.WIDTH(NUM_VOICES)) u_wave_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(wave_set_i),
      .take_i(wave_take), .wipe_i(wipe), .mask_o(wave_mask));

   voiceq_mask_bank #(.WIDTH(NUM_VOICES)) u_ramp_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ramp_set_i),
      .take_i(ramp_take), .wipe_i(wipe), .mask_o(ramp_mask));

   voiceq_prio_enc #(.WIDTH(NUM_VOICES), .SCAN(SCAN_VOICES), .IDX_W(IDX_W)) u_wave_enc (
      .req_i(wave_mask), .any_o(wave_any), .hit_o(wave_hit),
      .grant_o(wave_grant), .idx_o(wave_idx));

   voiceq_prio_enc #(.WIDTH(NUM_VOICES), .SCAN(SCAN_VOICES), .IDX_W(IDX_W)) u_ramp_enc (
      .req_i(ramp_mask), .any_o(ramp_any), .hit_o(ramp_hit),
      .grant_o(ramp_grant), .idx_o(ramp_idx));

   voiceq_pop_ctrl #(.WIDTH(NUM_VOICES), .IDX_W(IDX_W)) u_pop (
      .clk_i(clk_i), .rst_ni(rst_ni), .pop_i(pop),
      .wave_any_i(wave_any), .wave_hit_i(wave_hit),
      .wave_grant_i(wave_grant), .wave_idx_i(wave_idx),
      .ramp_hit_i(ramp_hit), .ramp_grant_i(ramp_grant), .ramp_idx_i(ramp_idx),
      .wave_take_o(wave_take), .ramp_take_o(ramp_take),
      .status_o(status_o), .wave_clr_o(wave_clr_o), .ramp_clr_o(ramp_clr_o));

   assign gstat_wave_o = wave_any;
   assign gstat_ramp_o = ramp_any;
   assign irq_o        = wave_any | ramp_any | other_irq_i;

endmodule

// File: rtl/voice_irq_queue_chk.sv
module voice_irq_queue_chk #(
   parameter int NUM_VOICES = 32
) (
   input logic                  clk_i,
   input logic                  rst_ni,
   input logic [NUM_VOICES-1:0] wave_set_i,
   input logic [NUM_VOICES-1:0] ramp_set_i,
   input logic                  fsel_wr_i,
   input logic [7:0]            fsel_data_i,
   input logic                  crst_wr_i,
   input logic [7:0]            crst_data_i,
   input logic [7:0]            status_o,
   input logic [NUM_VOICES-1:0] wave_clr_o,
   input logic [NUM_VOICES-1:0] ramp_clr_o,
   input logic                  gstat_wave_o,
   input logic                  gstat_ramp_o,
   input logic                  irq_o
);

   logic wipe_c, pop_c;
   assign wipe_c = crst_wr_i && !crst_data_i[0];
   assign pop_c  = fsel_wr_i && (fsel_data_i == 8'h8F) && !wipe_c;

   AST_NO_POP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pop_c |=> $stable(status_o) && wave_clr_o == '0 && ramp_clr_o == '0); // R1

   AST_WAVE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_c && gstat_wave_o |=> ramp_clr_o == '0); // R3

   AST_IDLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_c && !gstat_wave_o && !gstat_ramp_o |=> status_o == 8'hE8); // R4

   AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({wave_clr_o, ramp_clr_o})); // R5

   AST_SET_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wipe_c && (|wave_set_i) |=> gstat_wave_o); // R6

   AST_IRQ_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wipe_c && (|ramp_set_i) |=> irq_o); // R7

   AST_WIPE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wipe_c |=> !gstat_wave_o && !gstat_ramp_o); // R8

endmodule

bind voice_irq_queue voice_irq_queue_chk #(.NUM_VOICES(NUM_VOICES)) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .wave_set_i(wave_set_i), .ramp_set_i(ramp_set_i),
   .fsel_wr_i(fsel_wr_i), .fsel_data_i(fsel_data_i), .crst_wr_i(crst_wr_i),
   .crst_data_i(crst_data_i), .status_o(status_o), .wave_clr_o(wave_clr_o),
   .ramp_clr_o(ramp_clr_o), .gstat_wave_o(gstat_wave_o), .gstat_ramp_o(gstat_ramp_o),
   .irq_o(irq_o));

// File: tb/tb_voice_irq_queue.sv
`timescale 1ns/1ps
module tb_voice_irq_queue;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] wave_set = '0, ramp_set = '0;
   logic        fsel_wr = 1'b0, crst_wr = 1'b0, other_irq = 1'b0;
   logic [7:0]  fsel_data = '0, crst_data = 8'hFF;
   logic [7:0]  status;
   logic [31:0] wave_clr, ramp_clr;
   logic        gstat_wave, gstat_ramp, irq;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   voice_irq_queue dut (
      .clk_i(clk), .rst_ni(rst_n), .wave_set_i(wave_set), .ramp_set_i(ramp_set),
      .fsel_wr_i(fsel_wr), .fsel_data_i(fsel_data), .crst_wr_i(crst_wr),
      .crst_data_i(crst_data), .other_irq_i(other_irq), .status_o(status),
      .wave_clr_o(wave_clr), .ramp_clr_o(ramp_clr), .gstat_wave_o(gstat_wave),
      .gstat_ramp_o(gstat_ramp), .irq_o(irq));

   // Behavioural reference: two pending sets and a status byte.
   bit [31:0] m_wave = '0, m_ramp = '0, m_wclr = '0, m_rclr = '0;
   bit [7:0]  m_status = 8'hE8;

   always @(posedge clk) begin
      bit [31:0] nw, nr;
      bit taken, do_pop, do_wipe;
      nw = m_wave; nr = m_ramp; m_wclr = '0; m_rclr = '0;
      if (!rst_n) begin
         m_wave = '0; m_ramp = '0; m_status = 8'hE8;
      end else begin
         do_wipe = crst_wr && !crst_data[0];
         do_pop  = fsel_wr && fsel_data == 8'h8F && !do_wipe;
         if (do_pop) begin
            taken = 0;
            m_status = 8'hE8;
            if (m_wave != 0) begin
               for (int v = 0; v < 31; v++)
                  if (!taken && m_wave[v]) begin
                     taken = 1; nw[v] = 0; m_wclr[v] = 1; m_status = 8'h60 | 8'(v);
                  end
            end else if (m_ramp != 0) begin
               for (int v = 0; v < 31; v++)
                  if (!taken && m_ramp[v]) begin
                     taken = 1; nr[v] = 0; m_rclr[v] = 1; m_status = 8'h80 | 8'(v);
                  end
            end
         end
         if (do_wipe) begin
            m_wave = '0; m_ramp = '0;
         end else begin
            m_wave = nw | wave_set; m_ramp = nr | ramp_set;
         end
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model, away from the clock edge.
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         chk("R4 status", {24'b0, status}, {24'b0, m_status});
         chk("R5 wave_clr", wave_clr, m_wclr);
         chk("R5 ramp_clr", ramp_clr, m_rclr);
         chk("R6 gstat_wave", {31'b0, gstat_wave}, {31'b0, m_wave != 0});
         chk("R6 gstat_ramp", {31'b0, gstat_ramp}, {31'b0, m_ramp != 0});
         chk("R7 irq", {31'b0, irq}, {31'b0, (m_wave != 0) || (m_ramp != 0) || other_irq});
      end
   end

   task automatic pulse(logic [31:0] w, logic [31:0] r);
      wave_set = w; ramp_set = r;
      @(negedge clk);
      wave_set = '0; ramp_set = '0;
   endtask

   task automatic fsel(logic [7:0] d);
      fsel_wr = 1'b1; fsel_data = d;
      @(negedge clk);
      fsel_wr = 1'b0; fsel_data = '0;
   endtask

   task automatic crst(logic [7:0] d);
      crst_wr = 1'b1; crst_data = d;
      @(negedge clk);
      crst_wr = 1'b0; crst_data = 8'hFF;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R4 reset status", {24'b0, status}, 32'hE8);
      chk("R6 reset gstat", {30'b0, gstat_wave, gstat_ramp}, 32'h0);
      chk("R7 reset irq", {31'b0, irq}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: pop with nothing pending
      fsel(8'h8F);
      chk("R4 empty pop", {24'b0, status}, 32'hE8);

      // R2/R3: ordering across both masks
      pulse(32'h0000_0084, 32'h0000_0208);
      chk("R6 both set", {30'b0, gstat_wave, gstat_ramp}, 32'h3);
      fsel(8'h8F);
      chk("R2 lowest wave", {24'b0, status}, 32'h62);
      chk("R5 clr wave 2", wave_clr, 32'h4);
      chk("R3 ramp untouched", ramp_clr, 32'h0);
      fsel(8'h8F);
      chk("R3 wave before ramp", {24'b0, status}, 32'h67);
      chk("R6 wave empty", {31'b0, gstat_wave}, 32'h0);
      fsel(8'h8F);
      chk("R4 ramp code", {24'b0, status}, 32'h83);
      chk("R5 clr ramp 3", ramp_clr, 32'h8);
      fsel(8'h8F);
      chk("R2 next ramp", {24'b0, status}, 32'h89);
      chk("R7 irq drops", {31'b0, irq}, 32'h0);
      fsel(8'h8F);
      chk("R4 idle again", {24'b0, status}, 32'hE8);

      // R1: other function-select values do nothing
      pulse(32'h1, 32'h0);
      fsel(8'h0F);
      chk("R1 no pop status", {24'b0, status}, 32'hE8);
      chk("R1 no strobe", wave_clr, 32'h0);
      fsel(8'h8E);
      chk("R1 still pending", {31'b0, gstat_wave}, 32'h1);
      fsel(8'h8F);
      chk("R1 real pop", {24'b0, status}, 32'h60);

      // R9: set and pop of the same voice in one cycle
      pulse(32'h20, 32'h0);
      wave_set = 32'h20;
      fsel(8'h8F);
      wave_set = '0;
      chk("R9 status", {24'b0, status}, 32'h65);
      chk("R9 kept", {31'b0, gstat_wave}, 32'h1);
      fsel(8'h8F);
      chk("R9 popped again", {24'b0, status}, 32'h65);
      chk("R9 now empty", {31'b0, gstat_wave}, 32'h0);

      // R10: unscanned voice 31 blocks the ramp mask
      pulse(32'h8000_0000, 32'h10);
      fsel(8'h8F);
      chk("R10 idle code", {24'b0, status}, 32'hE8);
      chk("R10 no wave clr", wave_clr, 32'h0);
      chk("R10 no ramp clr", ramp_clr, 32'h0);
      chk("R10 ramp kept", {30'b0, gstat_wave, gstat_ramp}, 32'h3);

      // R8: card reset behaviour
      crst(8'h01);
      chk("R8 bit0 high no effect", {30'b0, gstat_wave, gstat_ramp}, 32'h3);
      wave_set = 32'h40;
      fsel_wr = 1'b1; fsel_data = 8'h8F;
      crst(8'h00);
      wave_set = '0; fsel_wr = 1'b0;
      chk("R8 masks wiped", {30'b0, gstat_wave, gstat_ramp}, 32'h0);
      chk("R8 pop cancelled", {24'b0, status}, 32'hE8);
      chk("R8 irq low", {31'b0, irq}, 32'h0);

      // R7: another source keeps the request up
      other_irq = 1'b1;
      #1;
      chk("R7 other source", {31'b0, irq}, 32'h1);
      @(negedge clk);
      other_irq = 1'b0;

      // Random mix, compared each cycle against the model
      for (int i = 0; i < 4000; i++) begin
         wave_set  = $urandom & $urandom & $urandom & $urandom & $urandom;
         ramp_set  = $urandom & $urandom & $urandom & $urandom & $urandom;
         fsel_wr   = ($urandom % 3) == 0;
         fsel_data = (($urandom % 5) == 0) ? 8'($urandom) : 8'h8F;
         crst_wr   = ($urandom % 97) == 0;
         crst_data = 8'($urandom);
         other_irq = ($urandom % 7) == 0;
         @(negedge clk);
      end
      wave_set = '0; ramp_set = '0; fsel_wr = 0; crst_wr = 0; other_irq = 0;
      repeat (2) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule